// File: doc/BRIEF.md
# Control Register Write Guard

This block sits in front of a small set of processor control registers and decides, for every write, whether it may take effect. It holds its own copy of five registers: a mode-control word, a translation-table base word, a feature-enable word, a task-priority word and a vector-unit control/status word. Each write names one register with a 3-bit selector and carries the new value and a flag that says whether the wide (64-bit) execution mode is active.

A write is rejected, and flagged as a general-protection fault, when it sets bits that the block treats as reserved or when it forms a forbidden combination in the mode-control word. Forbidden combinations are address translation on with protection off, write-through disabled with caching enabled, and translation off while the wide mode is active. A rejected write leaves every stored register as it was. An accepted write replaces only the register it names. The verdict is registered and appears one cycle after the write strobe. An accepted value can be read on the combinational read port from that same cycle. The reserved-bit masks are parameters.

Top module: `ctlreg_guard`

## Requirements
- R1: After synchronous reset the mode-control word (selector 0) reads 0x6000_0000, with bits 30 and 29 set. Selectors 1 to 4 read zero, and resp_valid and resp_fault are low.
- R2: resp_valid is high in exactly the cycle after each cycle with wr_en high, and low otherwise. resp_fault is never high without resp_valid. An accepted value reads back on rd_data from the cycle in which resp_valid rises.
- R3: A mode-control write with bit 31 (translation enable) set and bit 0 (protection enable) clear is rejected.
- R4: A mode-control write with bit 29 (write-through disable) set and bit 30 (cache disable) clear is rejected.
- R5: A mode-control write with bit 31 clear while wide_mode is high is rejected.
- R6: A write to the table base (selector 1), feature (selector 2) or priority (selector 3) word that has any bit set within that register's reserved mask is rejected. The default masks are 0x0000_0FE7, 0xFF80_0000 and 0xFFFF_FFF0.
- R7: A write to the vector control/status word (selector 4) with any bit set within its reserved mask is rejected. The default mask is 0xFFFF_0000.
- R8: A rejected write changes no stored register. An accepted write changes only the selected register, and it stores the written value unchanged.
- R9: Selectors 5, 6 and 7 name no register. A write to any of them is rejected, and reading any of them returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one request per cycle |
| wr_sel | input | 3 | Selector of the register to write |
| wr_data | input | 32 | Proposed new value |
| wide_mode | input | 1 | Wide execution mode is active |
| rd_sel | input | 3 | Selector for the read port |
| rd_data | output | 32 | Stored value of the selected register, combinational |
| resp_valid | output | 1 | Verdict for the previous cycle's write |
| resp_fault | output | 1 | That write was rejected |

## Verification
The assertions check on every cycle the timing of the verdict and the mode-control combinations that must fault (R2 to R5, R9). They also check that a register holds its value whenever no accepted write names it (R8). The reset contents, the full reserved-bit masks and the read-back of accepted values appear only in the bench's scenarios. The bench covers these with a sweep over all sixteen settings of the four mode-control bits in both modes, and with a single-bit walk across every other register. After each write it reads all five registers back.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int DW       = 32;
    localparam int NUM_REGS = 5;
    localparam int SEL_W    = 3;

    // bit positions inside the mode-control word
    localparam int BIT_PROT  = 0;
    localparam int BIT_WTHRU = 29;
    localparam int BIT_CDIS  = 30;
    localparam int BIT_XLATE = 31;

    localparam logic [SEL_W-1:0] SEL_MODE  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_TBASE = 3'd1;
    localparam logic [SEL_W-1:0] SEL_FEAT  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_PRIO  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_VSTAT = 3'd4;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic [DW-1:0]    data;
        logic             wide;
    } wreq_t;

    typedef struct packed {
        logic valid;
        logic fault;
    } resp_t;

    function automatic logic [DW-1:0] reset_value(int idx);
        logic [DW-1:0] v;
        v = '0;
        if (idx == 0) begin
            v[BIT_CDIS]  = 1'b1;
            v[BIT_WTHRU] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/ctlreg_rules.sv
module ctlreg_rules
    import ctlreg_pkg::*;
#(
    parameter logic [DW-1:0] RSV_TBASE = 32'h0000_0FE7,
    parameter logic [DW-1:0] RSV_FEAT  = 32'hFF80_0000,
    parameter logic [DW-1:0] RSV_PRIO  = 32'hFFFF_FFF0,
    parameter logic [DW-1:0] RSV_VSTAT = 32'hFFFF_0000
) (
    input  wreq_t req,
    output logic  fault
);

    logic xlate_no_prot;
    logic wt_no_cache;
    logic wide_no_xlate;

    always_comb begin
        xlate_no_prot = req.data[BIT_XLATE] & ~req.data[BIT_PROT];
        wt_no_cache   = req.data[BIT_WTHRU] & ~req.data[BIT_CDIS];
        wide_no_xlate = req.wide & ~req.data[BIT_XLATE];
    end

    always_comb begin
        case (req.sel)
            SEL_MODE:  fault = xlate_no_prot | wt_no_cache | wide_no_xlate;
            SEL_TBASE: fault = |(req.data & RSV_TBASE);
            SEL_FEAT:  fault = |(req.data & RSV_FEAT);
            SEL_PRIO:  fault = |(req.data & RSV_PRIO);
            SEL_VSTAT: fault = |(req.data & RSV_VSTAT);
            default:   fault = 1'b1;
        endcase
    end

endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
    import ctlreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wreq_t            req,
    input  logic             accept,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [DW-1:0]    rd_data
);

    logic [DW-1:0] store [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(i);
        logic hit;
        assign hit = req.en && accept && (req.sel == MY_SEL);

        always_ff @(posedge clk) begin
            if (rst)
                store[i] <= reset_value(i);
            else if (hit)
                store[i] <= req.data;
        end

        // R8
        untouched_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !(req.en && accept && req.sel == MY_SEL) |=> $stable(store[i]));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_sel == SEL_W'(i))
                rd_data = store[i];
    end

endmodule

// File: rtl/ctlreg_guard.sv
module ctlreg_guard
    import ctlreg_pkg::*;
#(
    parameter logic [DW-1:0] RSV_TBASE = 32'h0000_0FE7,
    parameter logic [DW-1:0] RSV_FEAT  = 32'hFF80_0000,
    parameter logic [DW-1:0] RSV_PRIO  = 32'hFFFF_FFF0,
    parameter logic [DW-1:0] RSV_VSTAT = 32'hFFFF_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic             wide_mode,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [DW-1:0]    rd_data,
    output logic             resp_valid,
    output logic             resp_fault
);

    wreq_t req;
    resp_t resp_q;
    logic  fault;

    assign req = '{en: wr_en, sel: wr_sel, data: wr_data, wide: wide_mode};

    ctlreg_rules #(
        .RSV_TBASE(RSV_TBASE),
        .RSV_FEAT (RSV_FEAT),
        .RSV_PRIO (RSV_PRIO),
        .RSV_VSTAT(RSV_VSTAT)
    ) u_rules (
        .req  (req),
        .fault(fault)
    );

    ctlreg_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .accept (~fault),
        .rd_sel (rd_sel),
        .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst)
            resp_q <= '0;
        else
            resp_q <= '{valid: wr_en, fault: wr_en & fault};
    end

    assign resp_valid = resp_q.valid;
    assign resp_fault = resp_q.fault;

    // R2
    resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> resp_valid);
    // R2
    resp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !resp_valid && !resp_fault);
    // R3
    xlate_noprot_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_sel == SEL_MODE && wr_data[BIT_XLATE] && !wr_data[BIT_PROT]
        |=> resp_fault);
    // R4
    wthru_nocache_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_sel == SEL_MODE && wr_data[BIT_WTHRU] && !wr_data[BIT_CDIS]
        |=> resp_fault);
    // R5
    wide_xlate_off_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_sel == SEL_MODE && wide_mode && !wr_data[BIT_XLATE]
        |=> resp_fault);
    // R9
    bad_sel_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_sel >= SEL_W'(NUM_REGS) |=> resp_fault);

endmodule

// File: tb/ctlreg_guard_test.sv
module ctlreg_guard_test;

    localparam time CLK_PERIOD = 10;
    localparam logic [31:0] M_TBASE = 32'h0000_0FE7;
    localparam logic [31:0] M_FEAT  = 32'hFF80_0000;
    localparam logic [31:0] M_PRIO  = 32'hFFFF_FFF0;
    localparam logic [31:0] M_VSTAT = 32'hFFFF_0000;

    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0;
    logic [2:0]  wr_sel = 0;
    logic [31:0] wr_data = 0;
    logic        wide_mode = 0;
    logic [2:0]  rd_sel = 0;
    logic [31:0] rd_data;
    logic        resp_valid, resp_fault;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    ctlreg_guard uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .wide_mode(wide_mode), .rd_sel(rd_sel),
        .rd_data(rd_data), .resp_valid(resp_valid), .resp_fault(resp_fault)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_fault(input logic [2:0] s, input logic [31:0] d,
                                       input logic w);
        case (s)
            3'd0: return (d[31] && !d[0]) || (d[29] && !d[30]) || (w && !d[31]);
            3'd1: return (d & M_TBASE) != 0;
            3'd2: return (d & M_FEAT) != 0;
            3'd3: return (d & M_PRIO) != 0;
            3'd4: return (d & M_VSTAT) != 0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic verify_all(input string tag);
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i);
            #1;
            if (i < 5) chk(rd_data == model[i], tag, rd_data, model[i]);
            else       chk(rd_data == 32'h0, "R9 unmapped read", rd_data, 32'h0);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d, input logic w,
                      input string tag);
        logic ef;
        ef = exp_fault(s, d, w);
        @(negedge clk);
        wr_en = 1; wr_sel = s; wr_data = d; wide_mode = w; rd_sel = s;
        @(posedge clk);
        #1;
        if (!ef && s < 5) model[s] = d;
        chk(resp_valid == 1'b1, "R2 valid after strobe", 32'(resp_valid), 32'h1);
        chk(resp_fault == ef, tag, 32'(resp_fault), 32'(ef));
        chk(rd_data == ((s < 5) ? model[s] : 32'h0), "R2 readback same cycle",
            rd_data, (s < 5) ? model[s] : 32'h0);
        @(negedge clk);
        wr_en = 0;
        verify_all("R8 stored values");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model[0] = 32'h6000_0000;
        for (int i = 1; i < 5; i++) model[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1
        chk(resp_valid == 1'b0, "R1 valid at reset", 32'(resp_valid), 32'h0);
        chk(resp_fault == 1'b0, "R1 fault at reset", 32'(resp_fault), 32'h0);
        verify_all("R1 reset contents");
        @(posedge clk); #1;
        chk(resp_valid == 1'b0, "R2 idle no response", 32'(resp_valid), 32'h0);

        // R3 R4 R5: every setting of the four mode bits, both modes
        for (int w = 0; w < 2; w++) begin
            for (int p = 0; p < 16; p++) begin
                logic [31:0] d;
                d = 32'h0001_0020;
                d[0]  = p[0];
                d[29] = p[1];
                d[30] = p[2];
                d[31] = p[3];
                wr(3'd0, d, w[0], "R3/R4/R5 mode verdict");
            end
        end

        // R6 R7: single-bit walk on each masked register
        for (int s = 1; s < 5; s++) begin
            for (int b = 0; b < 32; b++)
                wr(3'(s), 32'h1 << b, 1'b0, (s == 4) ? "R7 vector reserved" : "R6 reserved");
            wr(3'(s), 32'h0, 1'b0, "R8 zero accepted");
        end
        wr(3'd1, 32'hABCD_E018, 1'b0, "R6 multi-bit accept");
        wr(3'd2, 32'h007F_FFFF, 1'b0, "R6 all legal feature bits");
        wr(3'd4, 32'h0001_FFFF, 1'b0, "R7 one reserved with legal bits");

        // R9: unmapped selectors
        for (int s = 5; s < 8; s++)
            wr(3'(s), 32'h0, 1'b0, "R9 unmapped write");

        // back-to-back strobes
        @(negedge clk);
        wr_en = 1; wr_sel = 3'd3; wr_data = 32'h5; rd_sel = 3'd3;
        @(negedge clk);
        wr_data = 32'h9;
        #1;
        chk(rd_data == 32'h5, "R2 first of pair visible", rd_data, 32'h5);
        chk(resp_valid == 1'b1, "R2 first of pair valid", 32'(resp_valid), 32'h1);
        @(negedge clk);
        wr_en = 0;
        #1;
        chk(rd_data == 32'h9, "R2 second of pair visible", rd_data, 32'h9);
        chk(resp_valid == 1'b1, "R2 second of pair valid", 32'(resp_valid), 32'h1);
        @(negedge clk);
        #1;
        chk(resp_valid == 1'b0, "R2 drops after pair", 32'(resp_valid), 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule